// File: doc/BRIEF.md
# Miss-Recurrence Conflict Prefetcher

This block sits beside a direct-mapped first-level data cache. It forecasts conflict misses that come back again. It records the line address of every cache miss in a short shift history. When a miss hits a line that is already in that history, the block takes the number of misses recorded since that line's last appearance. It uses that count to forecast how many further misses will pass before the same line is needed again.

Each forecast becomes a pending prefetch. The pending prefetch carries a countdown of misses still to come. When the countdown falls to a programmable lookahead margin, the block requests the line from the next level. Its request always gives way to demand traffic on the shared port. Returned lines are kept in a small fully-associative side buffer, not in the cache. Cache lookups probe that buffer in the same cycle. A probe that hits takes the line and frees the slot.

Top module: `recur_pf`

## Requirements
- R1: After reset no prefetch request is raised and every probe misses.
- R2: The history holds the line addresses of the last HIST_DEPTH misses (8 by default), newest first, and drops the oldest. A forecast is made only if the missing line is among them. With 8 entries, a line that recurs after 7 other misses is forecast; one that recurs after 8 is not.
- R3: The forecast count is the number of misses recorded between the two misses of the line. It is the distance from the newest history entry to the nearest match, so an immediate repeat gives 0. The countdown drops by one on every later miss and stops at 0. The request becomes eligible once the countdown is at or below the `lookahead` input. The line requested is exactly the forecast line.
- R4: While `fetch_req_ready` is low, an eligible request stays raised with the same line. It is consumed only in a cycle where valid and ready are both high.
- R5: In any cycle with `demand_busy` high, `fetch_req_valid` is low. The deferred request is raised in the first cycle in which `demand_busy` is low.
- R6: A forecast for a line that already has a pending prefetch replaces that entry's countdown and adds no second entry, so the line is requested once.
- R7: When all PEND_SLOTS pending entries (4 by default) are in use, a forecast for a line not already pending is discarded.
- R8: A response (`fetch_rsp_valid`) installs its line and data in the side buffer. From the next cycle, a probe of that line gives `probe_hit` high and `probe_data` equal to the response data, in the same cycle as the probe.
- R9: A probe that hits removes the entry, so a second probe of the same line misses.
- R10: The side buffer replaces its least recently installed-or-refreshed line when it is full. A response for a line already present overwrites it in place and makes it most recent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A first-level miss occurs this cycle |
| miss_line | input | ADDR_W | Line address of that miss |
| lookahead | input | clog2(HIST_DEPTH) | Countdown value at or below which a prefetch may issue |
| demand_busy | input | 1 | A demand fetch owns the next-level request port this cycle |
| fetch_req_valid | output | 1 | Prefetch request to the next level |
| fetch_req_line | output | ADDR_W | Line address requested |
| fetch_req_ready | input | 1 | Next level accepts the request |
| fetch_rsp_valid | input | 1 | Returned prefetch line is present |
| fetch_rsp_line | input | ADDR_W | Line address of the returned data |
| fetch_rsp_data | input | LINE_W | Returned line contents |
| probe_valid | input | 1 | Cache lookup probes the side buffer |
| probe_line | input | ADDR_W | Line address probed |
| probe_hit | output | 1 | Probed line is present (combinational) |
| probe_data | output | LINE_W | Contents of the hitting line, zero on a miss |

## Verification
The bench targets an off-by-one in the recurrence count. Such an error shows up as a request one miss too early, which the scoreboard sees as an unexpected request, or one miss too late. It also targets the history edge: a line that recurs after 7 and after 8 intervening misses. A wrong depth either drops the first forecast or makes a stale second one. A repeated forecast while a prefetch is pending, and a forecast into a full pending table, both reveal a faulty design through an extra request some misses later. The bench holds ready low and demand busy high to catch a request that drifts or pushes into demand traffic. In the side buffer, a refresh before an eviction separates true LRU from plain insertion order.

// File: rtl/recur_pf_pkg.sv
package recur_pf_pkg;

   // How a returned line finds its slot in the side buffer
   typedef enum logic [1:0] {
      FILL_REFRESH = 2'd0,   // line already resident: overwrite in place
      FILL_FREE    = 2'd1,   // an empty slot is available
      FILL_EVICT   = 2'd2    // full: replace the least recent line
   } fill_kind_e;

endpackage

// File: rtl/recur_pf_history.sv
module recur_pf_history #(
   parameter  int ADDR_W = 26,
   parameter  int DEPTH  = 8,
   localparam int POS_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_line,
   output logic              hit,
   output logic [POS_W-1:0]  pos
);

   logic [ADDR_W-1:0] line_q [DEPTH];
   logic [DEPTH-1:0]  vld_q;
   logic [DEPTH-1:0]  match;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (line_q[g] == miss_line);
   end

   // nearest (most recent) match wins
   always_comb begin
      hit = 1'b0;
      pos = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit = 1'b1;
            pos = POS_W'(i);
         end
      end
      hit = hit & miss_valid;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else if (miss_valid) begin
         vld_q <= {vld_q[DEPTH-2:0], 1'b1};
      end
   end

   always_ff @(posedge clk) begin
      if (miss_valid) begin
         line_q[0] <= miss_line;
         for (int i = 1; i < DEPTH; i++) begin
            line_q[i] <= line_q[i-1];
         end
      end
   end

endmodule

// File: rtl/recur_pf_sched.sv
module recur_pf_sched #(
   parameter  int ADDR_W = 26,
   parameter  int SLOTS  = 4,
   parameter  int CNT_W  = 3,
   localparam int IDX_W  = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_line,
   input  logic              pred_valid,
   input  logic [CNT_W-1:0]  pred_cnt,
   input  logic [CNT_W-1:0]  lookahead,
   input  logic              demand_busy,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_line
);

   logic [SLOTS-1:0]  v_q;
   logic [ADDR_W-1:0] line_q [SLOTS];
   logic [CNT_W-1:0]  cnt_q  [SLOTS];

   logic [SLOTS-1:0]  same_vec, elig_vec;
   logic              same_any, free_any, elig_any, fire;
   logic [IDX_W-1:0]  same_idx, free_idx, elig_idx;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign same_vec[g] = v_q[g] && (line_q[g] == miss_line);
      assign elig_vec[g] = v_q[g] && (cnt_q[g] <= lookahead);
   end

   always_comb begin
      same_any = 1'b0; same_idx = '0;
      free_any = 1'b0; free_idx = '0;
      elig_any = 1'b0; elig_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (same_vec[i]) begin
            same_any = 1'b1;
            same_idx = IDX_W'(i);
         end
         if (!v_q[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
         if (elig_vec[i]) begin
            elig_any = 1'b1;
            elig_idx = IDX_W'(i);
         end
      end
   end

   // demand traffic owns the port; the prefetch simply waits
   assign req_valid = elig_any && !demand_busy;
   assign req_line  = line_q[elig_idx];
   assign fire      = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q <= '0;
      end else begin
         for (int i = 0; i < SLOTS; i++) begin
            if (fire && (elig_idx == IDX_W'(i))) v_q[i] <= 1'b0;
         end
         if (pred_valid) begin
            if (same_any)      v_q[same_idx] <= 1'b1;
            else if (free_any) v_q[free_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < SLOTS; i++) begin
         if (v_q[i] && miss_valid && (cnt_q[i] != '0)) cnt_q[i] <= cnt_q[i] - CNT_W'(1);
      end
      if (pred_valid) begin
         if (same_any) begin
            cnt_q[same_idx] <= pred_cnt;
         end else if (free_any) begin
            cnt_q[free_idx]  <= pred_cnt;
            line_q[free_idx] <= miss_line;
         end
      end
   end

endmodule

// File: rtl/recur_pf_pbuf.sv
module recur_pf_pbuf
   import recur_pf_pkg::*;
#(
   parameter  int ADDR_W = 26,
   parameter  int LINE_W = 64,
   parameter  int DEPTH  = 4,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int AGE_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_line,
   input  logic [LINE_W-1:0] fill_data,
   input  logic              probe_valid,
   input  logic [ADDR_W-1:0] probe_line,
   output logic              probe_hit,
   output logic [LINE_W-1:0] probe_data
);

   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(DEPTH - 1);

   logic [DEPTH-1:0]  v_q, nv;
   logic [ADDR_W-1:0] tag_q  [DEPTH];
   logic [LINE_W-1:0] data_q [DEPTH];
   logic [AGE_W-1:0]  age_q  [DEPTH];
   logic [AGE_W-1:0]  nage   [DEPTH];
   logic [DEPTH-1:0]  pm;

   logic              hit_any, ref_any, free_any;
   logic [IDX_W-1:0]  hit_idx, ref_idx, free_idx, old_idx, fill_idx;
   fill_kind_e        fill_kind;

   for (genvar g = 0; g < DEPTH; g++) begin : g_probe
      assign pm[g] = v_q[g] && (tag_q[g] == probe_line);
   end

   always_comb begin
      hit_any = 1'b0;
      hit_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (pm[i]) begin
            hit_any = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
      probe_hit  = probe_valid && hit_any;
      probe_data = probe_hit ? data_q[hit_idx] : '0;
   end

   // next state: first the probe consumes, then the fill installs
   always_comb begin
      nv = v_q;
      for (int i = 0; i < DEPTH; i++) nage[i] = age_q[i];

      if (probe_hit) begin
         nv[hit_idx] = 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            if (v_q[i] && (age_q[i] > age_q[hit_idx])) nage[i] = age_q[i] - AGE_W'(1);
         end
      end

      ref_any  = 1'b0; ref_idx  = '0;
      free_any = 1'b0; free_idx = '0;
      old_idx  = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (nv[i] && (tag_q[i] == fill_line)) begin
            ref_any = 1'b1;
            ref_idx = IDX_W'(i);
         end
         if (!nv[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
         if (nv[i] && (nage[i] == AGE_MAX)) old_idx = IDX_W'(i);
      end

      if (ref_any) begin
         fill_kind = FILL_REFRESH;
         fill_idx  = ref_idx;
      end else if (free_any) begin
         fill_kind = FILL_FREE;
         fill_idx  = free_idx;
      end else begin
         fill_kind = FILL_EVICT;
         fill_idx  = old_idx;
      end

      if (fill_valid) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (nv[i] && (IDX_W'(i) != fill_idx) &&
                ((fill_kind == FILL_FREE) || (nage[i] < nage[fill_idx]))) begin
               nage[i] = nage[i] + AGE_W'(1);
            end
         end
         nv[fill_idx]   = 1'b1;
         nage[fill_idx] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q <= '0;
         for (int i = 0; i < DEPTH; i++) age_q[i] <= '0;
      end else begin
         v_q <= nv;
         for (int i = 0; i < DEPTH; i++) age_q[i] <= nage[i];
      end
   end

   always_ff @(posedge clk) begin
      if (fill_valid) begin
         tag_q[fill_idx]  <= fill_line;
         data_q[fill_idx] <= fill_data;
      end
   end

endmodule

// File: rtl/recur_pf.sv
module recur_pf #(
   parameter  int ADDR_W     = 26,
   parameter  int LINE_W     = 64,
   parameter  int HIST_DEPTH = 8,
   parameter  int PEND_SLOTS = 4,
   parameter  int PBUF_DEPTH = 4,
   localparam int CNT_W      = $clog2(HIST_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_line,
   input  logic [CNT_W-1:0]  lookahead,
   input  logic              demand_busy,
   output logic              fetch_req_valid,
   output logic [ADDR_W-1:0] fetch_req_line,
   input  logic              fetch_req_ready,
   input  logic              fetch_rsp_valid,
   input  logic [ADDR_W-1:0] fetch_rsp_line,
   input  logic [LINE_W-1:0] fetch_rsp_data,
   input  logic              probe_valid,
   input  logic [ADDR_W-1:0] probe_line,
   output logic              probe_hit,
   output logic [LINE_W-1:0] probe_data
);

   if (HIST_DEPTH < 2) begin : g_bad_hist
      $error("recur_pf: HIST_DEPTH must be at least 2");
   end
   if (PEND_SLOTS < 2) begin : g_bad_pend
      $error("recur_pf: PEND_SLOTS must be at least 2");
   end
   if (PBUF_DEPTH < 2) begin : g_bad_pbuf
      $error("recur_pf: PBUF_DEPTH must be at least 2");
   end
   if (ADDR_W < 1 || LINE_W < 1) begin : g_bad_width
      $error("recur_pf: widths must be positive");
   end

   logic             pred_valid;
   logic [CNT_W-1:0] pred_cnt;

   recur_pf_history #(
      .ADDR_W (ADDR_W),
      .DEPTH  (HIST_DEPTH)
   ) u_hist (
      .clk        (clk),
      .rst        (rst),
      .miss_valid (miss_valid),
      .miss_line  (miss_line),
      .hit        (pred_valid),
      .pos        (pred_cnt)
   );

   recur_pf_sched #(
      .ADDR_W (ADDR_W),
      .SLOTS  (PEND_SLOTS),
      .CNT_W  (CNT_W)
   ) u_sched (
      .clk         (clk),
      .rst         (rst),
      .miss_valid  (miss_valid),
      .miss_line   (miss_line),
      .pred_valid  (pred_valid),
      .pred_cnt    (pred_cnt),
      .lookahead   (lookahead),
      .demand_busy (demand_busy),
      .req_ready   (fetch_req_ready),
      .req_valid   (fetch_req_valid),
      .req_line    (fetch_req_line)
   );

   recur_pf_pbuf #(
      .ADDR_W (ADDR_W),
      .LINE_W (LINE_W),
      .DEPTH  (PBUF_DEPTH)
   ) u_pbuf (
      .clk         (clk),
      .rst         (rst),
      .fill_valid  (fetch_rsp_valid),
      .fill_line   (fetch_rsp_line),
      .fill_data   (fetch_rsp_data),
      .probe_valid (probe_valid),
      .probe_line  (probe_line),
      .probe_hit   (probe_hit),
      .probe_data  (probe_data)
   );

endmodule

// File: rtl/recur_pf_chk.sv
module recur_pf_chk #(
   parameter int ADDR_W = 26
) (
   input logic              clk,
   input logic              rst,
   input logic              demand_busy,
   input logic              fetch_req_valid,
   input logic              fetch_rsp_valid,
   input logic [ADDR_W-1:0] fetch_rsp_line,
   input logic              probe_valid,
   input logic [ADDR_W-1:0] probe_line,
   input logic              probe_hit
);

   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !fetch_req_valid);

   p_yield_to_demand_r5: assert property (@(posedge clk) disable iff (rst)
      demand_busy |-> !fetch_req_valid);

   p_probe_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
      probe_hit |-> probe_valid);

   p_fill_visible_r8: assert property (@(posedge clk) disable iff (rst)
      fetch_rsp_valid |=> (!(probe_valid && (probe_line == $past(fetch_rsp_line))) || probe_hit));

   p_hit_consumed_r9: assert property (@(posedge clk) disable iff (rst)
      (probe_hit && !fetch_rsp_valid) |=>
         !(probe_valid && (probe_line == $past(probe_line)) && probe_hit));

endmodule

bind recur_pf recur_pf_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk             (clk),
   .rst             (rst),
   .demand_busy     (demand_busy),
   .fetch_req_valid (fetch_req_valid),
   .fetch_rsp_valid (fetch_rsp_valid),
   .fetch_rsp_line  (fetch_rsp_line),
   .probe_valid     (probe_valid),
   .probe_line      (probe_line),
   .probe_hit       (probe_hit)
);

// File: tb/recur_pf_bench.sv
`timescale 1ns/100ps
module recur_pf_bench;

   localparam int AW = 26;
   localparam int DW = 64;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          miss_valid = 1'b0;
   logic [AW-1:0] miss_line = '0;
   logic [CW-1:0] lookahead = '0;
   logic          demand_busy = 1'b0;
   logic          fetch_req_valid;
   logic [AW-1:0] fetch_req_line;
   logic          fetch_req_ready = 1'b1;
   logic          fetch_rsp_valid = 1'b0;
   logic [AW-1:0] fetch_rsp_line = '0;
   logic [DW-1:0] fetch_rsp_data = '0;
   logic          probe_valid = 1'b0;
   logic [AW-1:0] probe_line = '0;
   logic          probe_hit;
   logic [DW-1:0] probe_data;

   always #2.5 clk = ~clk;

   recur_pf u_recur_pf (
      .clk(clk), .rst(rst),
      .miss_valid(miss_valid), .miss_line(miss_line),
      .lookahead(lookahead), .demand_busy(demand_busy),
      .fetch_req_valid(fetch_req_valid), .fetch_req_line(fetch_req_line),
      .fetch_req_ready(fetch_req_ready),
      .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_line(fetch_rsp_line),
      .fetch_rsp_data(fetch_rsp_data),
      .probe_valid(probe_valid), .probe_line(probe_line),
      .probe_hit(probe_hit), .probe_data(probe_data)
   );

   int            n_cmp = 0;
   int            n_bad = 0;
   bit            finished = 1'b0;
   logic [AW-1:0] exp_q [$];
   logic [AW-1:0] mon_exp;
   logic          rsp_pend = 1'b0;
   logic [AW-1:0] rsp_pend_line = '0;

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {a, 12'h5a3, a};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // monitor: pops the scoreboard on every accepted request
   always @(negedge clk) begin
      if (!rst && fetch_req_valid) begin
         if (demand_busy) chk(1'b0, "R5 request raised under demand", 64'd1, 64'd0);
         if (fetch_req_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected prefetch request", 64'(fetch_req_line), 64'd0);
            end else begin
               mon_exp = exp_q.pop_front();
               chk(fetch_req_line == mon_exp, "R3 prefetch line", 64'(fetch_req_line), 64'(mon_exp));
            end
         end
      end
   end

   // next-level model: answers one cycle after acceptance
   always @(negedge clk) begin
      rsp_pend      = !rst && fetch_req_valid && fetch_req_ready;
      rsp_pend_line = fetch_req_line;
   end

   always @(posedge clk) begin
      #1;
      fetch_rsp_valid = rsp_pend;
      fetch_rsp_line  = rsp_pend_line;
      fetch_rsp_data  = pat(rsp_pend_line);
   end

   // all tasks start and end one time unit after a rising edge
   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic miss(input logic [AW-1:0] l);
      miss_valid = 1'b1;
      miss_line  = l;
      @(posedge clk);
      #1;
      miss_valid = 1'b0;
   endtask

   task automatic probe(input logic [AW-1:0] l, input bit eh, input string req);
      probe_valid = 1'b1;
      probe_line  = l;
      #0.5;
      chk(probe_hit == eh, req, 64'(probe_hit), 64'(eh));
      if (eh) chk(probe_data == pat(l), req, probe_data, pat(l));
      @(posedge clk);
      #1;
      probe_valid = 1'b0;
   endtask

   task automatic drained(input string req);
      chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         report();
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst = 1'b0;

      // R1: quiet after reset
      chk(fetch_req_valid == 1'b0, "R1 no request after reset", 64'(fetch_req_valid), 64'd0);
      probe(26'h000, 1'b0, "R1 probe misses after reset");

      // R3: recurrence after two other misses, zero margin
      lookahead = 3'd0;
      miss(26'h101); miss(26'h102); miss(26'h103); miss(26'h101);
      miss(26'h104);
      chk(fetch_req_valid == 1'b0, "R3 not eligible one miss early", 64'(fetch_req_valid), 64'd0);
      exp_q.push_back(26'h101);
      miss(26'h105);
      idle(4);
      drained("R3 recurrence prefetch issued");
      // R8 / R9: probe takes the line then it is gone
      probe(26'h101, 1'b1, "R8 probe hit returns data");
      probe(26'h101, 1'b0, "R9 second probe misses");

      // R3: margin of two, count three
      lookahead = 3'd2;
      miss(26'h201); miss(26'h202); miss(26'h203); miss(26'h204); miss(26'h201);
      chk(fetch_req_valid == 1'b0, "R3 count above margin", 64'(fetch_req_valid), 64'd0);
      exp_q.push_back(26'h201);
      miss(26'h205);
      idle(4);
      drained("R3 margin prefetch issued");

      // R4: ready held low
      lookahead = 3'd7;
      fetch_req_ready = 1'b0;
      miss(26'h301); miss(26'h301);
      chk(fetch_req_valid && fetch_req_line == 26'h301, "R4 request raised", 64'(fetch_req_line), 64'h301);
      idle(3);
      chk(fetch_req_valid && fetch_req_line == 26'h301, "R4 request held stable", 64'(fetch_req_line), 64'h301);
      exp_q.push_back(26'h301);
      fetch_req_ready = 1'b1;
      idle(4);
      drained("R4 request consumed on ready");

      // R5: demand priority
      demand_busy = 1'b1;
      miss(26'h401); miss(26'h401);
      chk(fetch_req_valid == 1'b0, "R5 yields to demand", 64'(fetch_req_valid), 64'd0);
      idle(3);
      chk(fetch_req_valid == 1'b0, "R5 still yielding", 64'(fetch_req_valid), 64'd0);
      exp_q.push_back(26'h401);
      demand_busy = 1'b0;
      #0.5;
      chk(fetch_req_valid && fetch_req_line == 26'h401, "R5 retry on idle cycle", 64'(fetch_req_line), 64'h401);
      idle(4);
      drained("R5 deferred prefetch issued");

      // R2: history edge, 7 intervening forecast, 8 not
      lookahead = 3'd7;
      miss(26'h501);
      for (int k = 0; k < 7; k++) miss(26'h510 + 26'(k));
      exp_q.push_back(26'h501);
      miss(26'h501);
      idle(4);
      drained("R2 recurrence within depth forecast");
      miss(26'h601);
      for (int k = 0; k < 8; k++) miss(26'h610 + 26'(k));
      miss(26'h601);
      chk(fetch_req_valid == 1'b0, "R2 recurrence beyond depth ignored", 64'(fetch_req_valid), 64'd0);
      idle(4);

      // R6: repeated forecast updates the pending entry
      lookahead = 3'd0;
      miss(26'h701); miss(26'h702); miss(26'h703); miss(26'h704); miss(26'h701);
      exp_q.push_back(26'h701);
      miss(26'h701);
      idle(3);
      drained("R6 updated entry issued");
      for (int k = 0; k < 5; k++) miss(26'h711 + 26'(k));
      idle(4);
      drained("R6 no duplicate request");

      // R7: full pending table drops the fifth forecast
      for (int k = 0; k < 5; k++) miss(26'h801 + 26'(k));
      for (int k = 0; k < 4; k++) miss(26'h801 + 26'(k));
      exp_q.push_back(26'h801);
      miss(26'h805);
      for (int k = 0; k < 3; k++) begin
         exp_q.push_back(26'h802 + 26'(k));
         miss(26'h811 + 26'(k));
      end
      miss(26'h814); miss(26'h815); miss(26'h816);
      idle(5);
      drained("R7 only four prefetches, fifth dropped");

      // R10: LRU with a refresh
      rst = 1'b1;
      idle(2);
      rst = 1'b0;
      lookahead = 3'd7;
      for (int k = 0; k < 4; k++) begin
         exp_q.push_back(26'h901 + 26'(k));
         miss(26'h901 + 26'(k));
         miss(26'h901 + 26'(k));
         idle(3);
      end
      exp_q.push_back(26'h901);
      miss(26'h901);
      idle(3);
      exp_q.push_back(26'h905);
      miss(26'h905); miss(26'h905);
      idle(4);
      drained("R10 refill prefetches issued");
      probe(26'h902, 1'b0, "R10 least recent line evicted");
      probe(26'h901, 1'b1, "R10 refreshed line kept");
      probe(26'h903, 1'b1, "R10 line kept");
      probe(26'h904, 1'b1, "R10 line kept");
      probe(26'h905, 1'b1, "R10 newest line kept");

      idle(5);
      drained("R3 scoreboard empty at end");
      finished = 1'b1;
      report();
      $finish;
   end

endmodule